// File: doc/BRIEF.md
# Operand Forwarding Selection Unit

This block picks where each ALU operand of a five-stage pipeline comes from while the consuming instruction sits in the execute stage. For each of the two source register numbers it compares against the pending writes held in the two pipeline registers behind the ALU: the execute/memory register (the youngest older instruction) and the memory/write-back register. It drives a two-bit select code per operand toward the external datapath mux, choosing the register-file value, the ALU result from the execute/memory register, or the result in the memory/write-back register.

A second, single-bit select serves store data in the memory stage. When a load sits in write-back and the store right behind it in the memory stage stores the register that load writes, the loaded value bypasses the stale store data. The unit is purely combinational and holds no state. A write landing in the register file in the same cycle as a decode read is served by the register file itself (write early, read late), so no third comparison path exists.

Top module: `fwd_select_unit`

## Requirements
- R1: When the execute/memory register holds a valid instruction with its write enable set and a nonzero destination equal to an operand's source, that operand's select is 2'b10.
- R2: When only the memory/write-back register holds such a matching valid, enabled, nonzero pending write, the operand's select is 2'b01.
- R3: When both registers match the same operand, the nearer execute/memory writer wins and the select is 2'b10.
- R4: A pending write whose destination is register 0 is never forwarded; with no other match the select is 2'b00.
- R5: A stage whose valid bit is low (a bubble) or whose write enable is low is never forwarded from.
- R6: With no qualifying match an operand's select is 2'b00 (register file); the code 2'b11 is never produced.
- R7: The first operand (rs) and second operand (rt) are resolved independently; a match on one does not change the other's select.
- R8: The store-data select is 1 exactly when a store is in the memory stage, the write-back stage is valid, write-enabled and a load, and the load's nonzero destination equals the store's data register; otherwise it is 0.
- R9: A non-load writer in write-back, or one whose destination is register 0, never sets the store-data select, even when the register numbers match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | First source register number of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register number of the instruction in execute |
| exm_valid | input | 1 | Execute/memory register holds a real instruction |
| exm_wen | input | 1 | That instruction writes a register |
| exm_dst | input | REG_AW | Its destination register number |
| mwb_valid | input | 1 | Memory/write-back register holds a real instruction |
| mwb_wen | input | 1 | That instruction writes a register |
| mwb_dst | input | REG_AW | Its destination register number |
| mwb_is_load | input | 1 | That instruction is a load |
| mem_is_store | input | 1 | A valid store occupies the memory stage |
| mem_st_reg | input | REG_AW | Register whose value the store writes to memory |
| alu_a_sel | output | 2 | Select for the first operand: 00 file, 10 exec/mem, 01 mem/wb |
| alu_b_sel | output | 2 | Select for the second operand, same encoding |
| st_data_sel | output | 1 | 1 = take store data from the load result in write-back |

## Verification
The embedded assertions watch every evaluation for an illegal select code, for any forward that names a bubble, a disabled writer or register 0, and for a store-data bypass fired without a load behind it. Whether the nearer writer actually wins, and whether a legitimate match is never missed, only shows up when the bench compares the selects against arithmetically predicted ones over a full sweep of all input combinations on a four-register configuration, together with directed cases for each priority and exclusion.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int NUM_OPS = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              valid,
  input  logic              wen,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic qualified;

  always_comb begin
    qualified = valid && wen && (dst != ZERO_REG);
    hit       = qualified && (dst == src);
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     near_hit,
  input  logic     far_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (near_hit)     sel = FWD_EXM;
    else if (far_hit) sel = FWD_MWB;
    else              sel = FWD_RF;
  end

  always_comb begin
    if (near_hit)
      a_r3_near_wins: assert (sel == FWD_EXM)
        else $error("near writer lost priority");
  end
endmodule

// File: rtl/st_bypass.sv
module st_bypass #(
  parameter int REG_AW = 5
) (
  input  logic              store_here,
  input  logic              wb_is_load,
  input  logic              wb_hit,
  output logic              take_load
);
  always_comb begin
    take_load = store_here && wb_is_load && wb_hit;
  end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic              exm_valid,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              mwb_valid,
  input  logic              mwb_wen,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic              mwb_is_load,
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] mem_st_reg,
  output logic [1:0]        alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              st_data_sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic [REG_AW-1:0] src_idx  [NUM_OPS];
  logic              exm_hit  [NUM_OPS];
  logic              mwb_hit  [NUM_OPS];
  fwd_sel_e          op_sel   [NUM_OPS];
  logic              st_wb_hit;

  assign src_idx[0] = ex_src_a;
  assign src_idx[1] = ex_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_match #(.REG_AW(REG_AW)) u_exm (
      .src(src_idx[g]), .dst(exm_dst), .valid(exm_valid), .wen(exm_wen),
      .hit(exm_hit[g])
    );
    fwd_match #(.REG_AW(REG_AW)) u_mwb (
      .src(src_idx[g]), .dst(mwb_dst), .valid(mwb_valid), .wen(mwb_wen),
      .hit(mwb_hit[g])
    );
    fwd_prio u_prio (
      .near_hit(exm_hit[g]), .far_hit(mwb_hit[g]), .sel(op_sel[g])
    );
  end

  fwd_match #(.REG_AW(REG_AW)) u_st_match (
    .src(mem_st_reg), .dst(mwb_dst), .valid(mwb_valid), .wen(mwb_wen),
    .hit(st_wb_hit)
  );

  st_bypass #(.REG_AW(REG_AW)) u_st (
    .store_here(mem_is_store), .wb_is_load(mwb_is_load), .wb_hit(st_wb_hit),
    .take_load(st_data_sel)
  );

  assign alu_a_sel = op_sel[0];
  assign alu_b_sel = op_sel[1];

  always_comb begin
    a_r6_legal_code: assert (alu_a_sel != 2'b11 && alu_b_sel != 2'b11)
      else $error("illegal select code");
    if (alu_a_sel == 2'b10)
      a_r5_exm_qualified: assert (exm_valid && exm_wen && exm_dst == ex_src_a)
        else $error("forward from unqualified exec/mem writer");
    if (alu_b_sel == 2'b01)
      a_r5_mwb_qualified: assert (mwb_valid && mwb_wen && mwb_dst == ex_src_b)
        else $error("forward from unqualified mem/wb writer");
    if (alu_a_sel != 2'b00 || alu_b_sel != 2'b00)
      a_r4_no_zero_fwd: assert (!(alu_a_sel != 2'b00 && ex_src_a == ZERO_REG) &&
                                !(alu_b_sel != 2'b00 && ex_src_b == ZERO_REG))
        else $error("register 0 forwarded");
    if (st_data_sel)
      a_r9_store_needs_load: assert (mwb_is_load && mem_is_store && mwb_dst != ZERO_REG)
        else $error("store bypass without load");
  end
endmodule

// File: tb/tb_fwd_select_unit.sv
module tb_fwd_select_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] src_a, src_b, exm_dst, mwb_dst, st_reg;
  logic exm_valid, exm_wen, mwb_valid, mwb_wen, mwb_load, store;
  logic [1:0] a_sel, b_sel;
  logic st_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  fwd_select_unit #(.REG_AW(AW)) dut (
    .ex_src_a(src_a), .ex_src_b(src_b),
    .exm_valid(exm_valid), .exm_wen(exm_wen), .exm_dst(exm_dst),
    .mwb_valid(mwb_valid), .mwb_wen(mwb_wen), .mwb_dst(mwb_dst),
    .mwb_is_load(mwb_load), .mem_is_store(store), .mem_st_reg(st_reg),
    .alu_a_sel(a_sel), .alu_b_sel(b_sel), .st_data_sel(st_sel)
  );

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    bit near, far;
    near = exm_valid && exm_wen && exm_dst != 0 && exm_dst == s;
    far  = mwb_valid && mwb_wen && mwb_dst != 0 && mwb_dst == s;
    if (near) return 2'b10;      // R1, R3
    if (far)  return 2'b01;      // R2
    return 2'b00;                // R4, R5, R6
  endfunction

  function automatic logic exp_st();
    return store && mwb_valid && mwb_wen && mwb_load &&
           mwb_dst != 0 && mwb_dst == st_reg;   // R8, R9
  endfunction

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, want);
    end
  endtask

  task automatic apply(input logic [15:0] v);
    @(negedge clk);
    {src_a, src_b, exm_valid, exm_wen, exm_dst,
     mwb_valid, mwb_wen, mwb_dst, mwb_load, store, st_reg} = v;
    #1;
  endtask

  task automatic check_all(input string req);
    check({req, " opA"}, a_sel, exp_sel(src_a));
    check({req, " opB"}, b_sel, exp_sel(src_b));
    check({req, " store"}, {1'b0, st_sel}, {1'b0, exp_st()});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // idle: nothing pending -> R6
    apply(16'h0000);
    check("R6 idle opA", a_sel, 2'b00);
    check("R6 idle opB", b_sel, 2'b00);
    check("R8 idle store", {1'b0, st_sel}, 2'b00);
    // src_a=1,src_b=2, exm writes 1 -> R1 and R7 (b stays file)
    apply({2'd1, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0});
    check("R1 near hit", a_sel, 2'b10);
    check("R7 other op untouched", b_sel, 2'b00);
    // mwb writes 2 -> R2 on operand b
    apply({2'd1, 2'd2, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0});
    check("R5 exm bubble", a_sel, 2'b00);
    check("R2 far hit", b_sel, 2'b01);
    // both write 3 -> R3
    apply({2'd3, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0});
    check("R3 nearest wins A", a_sel, 2'b10);
    check("R3 nearest wins B", b_sel, 2'b10);
    // register 0 both stages -> R4
    apply({2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0});
    check("R4 zero reg A", a_sel, 2'b00);
    check("R4 zero store", {1'b0, st_sel}, 2'b00);
    // write enable low -> R5
    apply({2'd2, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd0});
    check("R5 wen low", a_sel, 2'b00);
    // load in wb writes 1, store of 1 -> R8
    apply({2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 2'd1});
    check("R8 load to store", {1'b0, st_sel}, 2'b01);
    // same but not a load -> R9
    apply({2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 2'd1});
    check("R9 non-load writer", {1'b0, st_sel}, 2'b00);

    // exhaustive sweep of all 16 input bits
    for (int v = 0; v < 65536; v++) begin
      apply(v[15:0]);
      check_all("R1-sweep R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule